// File: doc/BRIEF.md
# Fast Register-Triggered Serial Bit Shifter

This block drives a two-wire serial output, a bit clock and a data line, from a small register interface. Software first writes a control register. That register holds a static data level, a mode bit and a rate select. A single write to a second register then launches a short burst. The second register carries a bit count and up to five data bits. The block sends the requested bits least significant first. Each bit is XORed with the static data level before it reaches the data line.

Each bit occupies two phases of one time unit each. In the first phase the clock is low, and in the second it is high. The data bit stays steady for the whole bit. The time unit is either one input clock cycle or two, as the rate select chooses. A busy flag covers the burst, and a one-cycle done pulse marks its end. Between bursts the clock rests low and the data line shows the static level.

Top module: `fast_serial_shifter`

## Requirements
- R1: After reset, busy, done and ser_clk are 0, ser_dat is 0, and all control fields read as 0.
- R2: A write with addr=0 loads the control register: bit 0 is the static data level, bit 1 is the mode bit, and bit 2 is the rate select. A read with addr=0 returns these three bits in the same positions, with the upper bits 0.
- R3: A write with addr=1 and a count in wdata[7:5] of 1 to 5 is accepted at that clock edge. Busy is high from the next cycle. The bits wdata[4:0] are sent starting with bit 0, and exactly the count of bits is sent.
- R4: During a burst, ser_dat equals the current data bit XOR the static data level.
- R5: The time unit tA is 1 clock cycle when the rate select is 0 and 2 cycles when it is 1. Each bit shows ser_clk low for tA and then high for tA, and ser_dat changes only where ser_clk falls.
- R6: A burst of n bits keeps busy high for 2·n·tA cycles. In the cycle after that, busy is 0 and done is 1 for exactly one cycle.
- R7: A write with addr=1 and a count of 0, 6 or 7 starts nothing.
- R8: A write with addr=1 while the mode bit is 1 starts nothing.
- R9: A write with addr=1 while busy is high has no effect on the running burst and does not start a new one.
- R10: With rd_en=1 and addr=1, rdata returns the last accepted burst register value. With rd_en=0, rdata is 0. Reads never change ser_clk, ser_dat or busy.
- R11: While busy is 0, ser_clk is 0 and ser_dat equals the static data level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read enable |
| addr | input | 1 | 0 selects the control register, 1 selects the burst register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| ser_clk | output | 1 | Serial bit clock |
| ser_dat | output | 1 | Serial data line |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at the end of a burst |

## Verification
The bench builds the block with its default five-bit data field and three-bit count. This keeps the whole input space small enough to sweep every data pattern, every valid count, both static data levels and both rates, and to compare the pins cycle by cycle against an arithmetic model. It also reaches each rejected count value, the mode lock-out, a write that lands during a burst at the shortest and longest lengths, and register reads interleaved with idle time.

// File: rtl/fast_serial_shifter.sv
module fast_serial_shifter #(
  parameter int DATA_W = 5
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    wr_en,
  input  logic                                    rd_en,
  input  logic                                    addr,
  input  logic [DATA_W+$clog2(DATA_W+1)-1:0]      wdata,
  output logic [DATA_W+$clog2(DATA_W+1)-1:0]      rdata,
  output logic                                    ser_clk,
  output logic                                    ser_dat,
  output logic                                    busy,
  output logic                                    done
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int REG_W = DATA_W + CNT_W;
  localparam int PH_W  = CNT_W + 1;

  logic              sd_q, mode_q, half_q;
  logic [REG_W-1:0]  fast_q;
  logic [DATA_W-1:0] sh_q;
  logic [PH_W-1:0]   left_q;
  logic              busy_q, done_q, sclk_q, pre_q;

  wire [CNT_W-1:0] wcnt   = wdata[REG_W-1:DATA_W];
  wire             cnt_ok = (wcnt != '0) && (int'(wcnt) <= DATA_W);
  wire             launch = wr_en && addr && !busy_q && !mode_q && cnt_ok;
  wire             tick   = busy_q && (!half_q || pre_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_q   <= 1'b0;
      mode_q <= 1'b0;
      half_q <= 1'b0;
      fast_q <= '0;
      sh_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      pre_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (wr_en && !addr) begin
        sd_q   <= wdata[0];
        mode_q <= wdata[1];
        half_q <= wdata[2];
      end
      if (launch) begin
        fast_q <= wdata;
        sh_q   <= wdata[DATA_W-1:0];
        left_q <= {wcnt, 1'b0};
        busy_q <= 1'b1;
        sclk_q <= 1'b0;
        pre_q  <= 1'b0;
      end else if (busy_q) begin
        pre_q <= half_q ? ~pre_q : 1'b0;
        if (tick) begin
          left_q <= left_q - 1'b1;
          if (left_q == PH_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            sclk_q <= 1'b0;
          end else begin
            sclk_q <= ~sclk_q;
            if (sclk_q) sh_q <= sh_q >> 1;
          end
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr) rdata = fast_q;
      else      rdata = REG_W'({half_q, mode_q, sd_q});
    end
  end

  assign ser_clk = sclk_q;
  assign ser_dat = busy_q ? (sh_q[0] ^ sd_q) : sd_q;
  assign busy    = busy_q;
  assign done    = done_q;
endmodule

module fast_serial_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic addr,
  input logic ser_clk,
  input logic ser_dat,
  input logic busy,
  input logic done,
  input logic sd_q,
  input logic mode_q
);
  a_r11_idle_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_clk);
  a_r11_idle_dat: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_dat == sd_q);
  a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) && !busy);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_launch_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en) && $past(addr));
  a_r8_mode_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(mode_q));
  a_r5_dat_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(sd_q) && !$stable(ser_dat)) |-> $fell(ser_clk));
endmodule

bind fast_serial_shifter fast_serial_shifter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .ser_clk(ser_clk), .ser_dat(ser_dat), .busy(busy), .done(done),
  .sd_q(sd_q), .mode_q(mode_q)
);

// File: tb/sim_fast_serial_shifter.sv
module sim_fast_serial_shifter;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  wire  ser_clk, ser_dat, busy, done;
  int   checks = 0, errors = 0;
  logic [7:0] last_ok = '0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  fast_serial_shifter u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .busy(busy), .done(done)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(bit a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0;
  endtask

  task automatic idle_chk(string req, bit sd);
    chk({req, " busy"}, 8'(busy), 8'd0);
    chk({req, " clk"}, 8'(ser_clk), 8'd0);
    chk({req, " dat"}, 8'(ser_dat), 8'(sd));
  endtask

  task automatic run(int n, logic [4:0] d, bit sd, bit half, bit inject);
    int ta = half ? 2 : 1;
    int tot = 2 * n * ta;
    wr(1'b1, {3'(n), d});
    last_ok = {3'(n), d};
    for (int j = 1; j <= tot; j++) begin
      int p = (j - 1) / ta;
      chk("R3 busy during burst", 8'(busy), 8'd1);
      chk("R5 clock phase", 8'(ser_clk), 8'(p % 2));
      chk("R4 data xor", 8'(ser_dat), 8'(d[p / 2] ^ sd));
      if (inject && j == 2) begin
        wr_en = 1'b1; addr = 1'b1; wdata = 8'hA2;
      end else begin
        wr_en = 1'b0; addr = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0; addr = 1'b0;
    chk("R6 busy end", 8'(busy), 8'd0);
    chk("R6 done pulse", 8'(done), 8'd1);
    chk("R11 clk rest", 8'(ser_clk), 8'd0);
    chk("R11 dat rest", 8'(ser_dat), 8'(sd));
    @(negedge clk);
    chk("R6 done single", 8'(done), 8'd0);
    if (inject) chk("R9 no relaunch", 8'(busy), 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R1", 1'b0);
    chk("R1 done", 8'(done), 8'd0);
    rd_en = 1'b1; addr = 1'b0; #1;
    chk("R1 ctl read", rdata, 8'd0);
    rd_en = 1'b0;

    wr(1'b0, 8'h05);
    rd_en = 1'b1; addr = 1'b0; #1;
    chk("R2 ctl read", rdata, 8'h05);
    rd_en = 1'b0;
    wr(1'b0, 8'h02);
    rd_en = 1'b1; addr = 1'b0; #1;
    chk("R2 ctl read mode", rdata, 8'h02);
    rd_en = 1'b0;

    wr(1'b1, 8'h3F);
    idle_chk("R8 mode lock", 1'b0);
    @(negedge clk);
    idle_chk("R8 mode lock later", 1'b0);

    for (int s = 0; s < 2; s++) begin
      wr(1'b0, {5'b0, 1'b0, 1'b0, 1'(s)});
      for (int c = 0; c < 8; c++) begin
        if (c >= 1 && c <= 5) continue;
        wr(1'b1, {3'(c), 5'h15});
        idle_chk("R7 bad count", 1'(s));
        @(negedge clk);
        idle_chk("R7 bad count later", 1'(s));
      end
    end

    for (int h = 0; h < 2; h++)
      for (int s = 0; s < 2; s++) begin
        wr(1'b0, {5'b0, 1'(h), 1'b0, 1'(s)});
        for (int n = 1; n <= 5; n++)
          for (int d = 0; d < 32; d++)
            run(n, 5'(d), 1'(s), 1'(h), 1'b0);
      end

    wr(1'b0, 8'h01);
    run(1, 5'h01, 1'b1, 1'b0, 1'b1);
    run(5, 5'h16, 1'b1, 1'b0, 1'b1);
    wr(1'b0, 8'h04);
    run(5, 5'h09, 1'b0, 1'b1, 1'b1);

    @(negedge clk);
    rd_en = 1'b1; addr = 1'b1; #1;
    chk("R10 fast read", rdata, last_ok);
    @(negedge clk);
    idle_chk("R10 read no pin effect", 1'b0);
    rd_en = 1'b0; #1;
    chk("R10 read gated", rdata, 8'd0);
    wr(1'b1, 8'hE3);
    rd_en = 1'b1; addr = 1'b1; #1;
    chk("R7 rejected not stored", rdata, last_ok);
    rd_en = 1'b0;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule